// File: doc/BRIEF.md
# Eight-Digit Fixed-Point Display Driver with Zero Suppression

This block drives a seven-segment display of eight digits. Four integer digits stand to the left of a fixed decimal point and four fraction digits stand to its right. A single active-low load strobe captures all eight 4-bit digit codes together. The block then holds them and drives 56 active-low segment lines, seven per digit.

Two ripple-blanking chains remove zeros that carry no information. The integer chain starts at the thousands digit and moves toward the units digit, blanking leading zeros until it meets the first digit that is not zero. The units digit is never suppressed. The fraction chain is a mirror of the integer chain. It starts at the last fraction digit and moves toward the decimal point, blanking trailing zeros. With this scheme, `0060.0300` appears as `60.03`.

Display intensity is set by an 8-bit brightness input. A free-running counter generates a periodic forced-blank signal that overrides every digit. This gives duration-based dimming.

Top module: `zero_blank_display`

## Requirements
- R1: Digit k occupies code bits `digits_in[4k+3:4k]` and segment bits `seg_n[7k+6:7k]`. Digit 7 is the thousands digit, digit 4 is the units digit, digit 3 is the first fraction digit and digit 0 is the last fraction digit. Within each digit, bit 0 is segment a and bit 6 is segment g, and a 0 lights the segment. Codes 0 to 9 light these segments (gfedcba, 1 = lit): 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F.
- R2: Codes 10 to 15 show these glyphs: dash=40, E=79, H=76, L=38, P=73, and code 15 shows nothing (00).
- R3: A zero integer digit is blanked only if every integer digit more significant than it is also zero. A zero in the thousands digit is always blanked.
- R4: The units digit is never blanked by suppression, even when it and all integer digits above it are zero.
- R5: A zero fraction digit is blanked only if every fraction digit less significant than it is also zero. A fraction of 0000 shows entirely blank.
- R6: Codes 10 to 15 stop both suppression chains in the same way as a nonzero digit. This applies to code 15 as well, even though code 15 shows nothing.
- R7: A rising clock edge with `load_n` low captures all eight codes. Codes presented while `load_n` is high have no effect. The segment outputs reflect a load at the second rising edge after it.
- R8: An 8-bit counter advances on every clock. A digit may be lit only while the counter is below `brightness`. Over any 256 consecutive cycles with static data, exactly `brightness` cycles show lit segments, and a brightness of 0 keeps the display dark.
- R9: While `rst` is high, all segment outputs are high (dark), and the stored codes and the counter return to zero.
- R10: Loading `0060.0300` shows `60.03`. Digits 7, 6, 1 and 0 are dark, and digits 5, 4, 3 and 2 show 6, 0, 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low load strobe for all eight codes |
| digits_in | input | 32 | Eight 4-bit digit codes, digit 0 in the low bits |
| brightness | input | 8 | On-time in counter steps out of 256 |
| seg_n | output | 56 | Active-low segments, seven per digit |

## Verification
The bench targets zeros placed in the middle of a number. A chain that blanks every zero instead of stopping at the first nonzero digit would drop the 0 in `60.03`. An all-zero value is used to catch a design that lets the integer chain run through the units digit, which would leave a blank display with only a decimal point. An all-zero fraction and a trailing code 15 are used to catch designs that treat the dark glyph of code 15 as a zero, or that fail to carry the fraction chain all the way to the point. Duty counts at brightness 0, 1, 128 and 255 expose off-by-one errors in the on-time compare. Changing the codes while the strobe is high exposes a latch that stays transparent.

// File: rtl/zbd_pkg.sv
package zbd_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  // Active-high segment pattern, bit 0 = segment a, bit 6 = segment g
  function automatic seg_t glyph_on(code_t c);
    seg_t s;
    case (c)
      4'd0:  s = 7'h3F;
      4'd1:  s = 7'h06;
      4'd2:  s = 7'h5B;
      4'd3:  s = 7'h4F;
      4'd4:  s = 7'h66;
      4'd5:  s = 7'h6D;
      4'd6:  s = 7'h7D;
      4'd7:  s = 7'h07;
      4'd8:  s = 7'h7F;
      4'd9:  s = 7'h6F;
      4'd10: s = 7'h40; // dash
      4'd11: s = 7'h79; // E
      4'd12: s = 7'h76; // H
      4'd13: s = 7'h38; // L
      4'd14: s = 7'h73; // P
      default: s = 7'h00; // dark glyph
    endcase
    return s;
  endfunction
endpackage

// File: rtl/zbd_code_latch.sv
module zbd_code_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (!load_n) q <= d;
  end
endmodule

// File: rtl/zbd_pwm_gen.sv
module zbd_pwm_gen #(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PWM_W-1:0] level,
  output logic [PWM_W-1:0] cnt,
  output logic             on
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign on = (cnt < level);
endmodule

// File: rtl/zbd_ripple_chain.sv
// Element 0 is the head of the chain; its blanking input is tied asserted.
module zbd_ripple_chain #(
  parameter int N         = 4,
  parameter bit KEEP_TAIL = 1'b0
) (
  input  logic [N*zbd_pkg::CODE_W-1:0] codes,
  output logic [N-1:0]                 blank
);
  localparam int CW = zbd_pkg::CODE_W;

  logic [N:0] rb;
  assign rb[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic is_zero;
    assign is_zero = (codes[i*CW +: CW] == '0);
    if (KEEP_TAIL && i == N-1) begin : g_keep
      assign blank[i] = 1'b0;
    end else begin : g_pass
      assign blank[i] = rb[i] & is_zero;
    end
    assign rb[i+1] = blank[i];
  end
endmodule

// File: rtl/zbd_digit_driver.sv
module zbd_digit_driver (
  input  logic                 clk,
  input  logic                 rst,
  input  zbd_pkg::code_t       code,
  input  logic                 suppress,
  input  logic                 pwm_on,
  output zbd_pkg::seg_t        seg_n
);
  import zbd_pkg::*;

  seg_t seg_d;
  always_comb begin
    if (pwm_on && !suppress) seg_d = ~glyph_on(code);
    else                     seg_d = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) seg_n <= '1;
    else     seg_n <= seg_d;
  end
endmodule

// File: rtl/zero_blank_display.sv
module zero_blank_display #(
  parameter int NUM_INT  = 4,
  parameter int NUM_FRAC = 4,
  parameter int PWM_W    = 8,
  localparam int NUM_DIG = NUM_INT + NUM_FRAC,
  localparam int CW      = zbd_pkg::CODE_W,
  localparam int SW      = zbd_pkg::SEG_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_n,
  input  logic [NUM_DIG*CW-1:0] digits_in,
  input  logic [PWM_W-1:0]      brightness,
  output logic [NUM_DIG*SW-1:0] seg_n
);
  logic [NUM_DIG*CW-1:0]  lat_codes;
  logic [PWM_W-1:0]       pwm_cnt;
  logic                   pwm_on;
  logic [NUM_INT*CW-1:0]  int_codes;
  logic [NUM_FRAC*CW-1:0] frac_codes;
  logic [NUM_INT-1:0]     int_blank;
  logic [NUM_FRAC-1:0]    frac_blank;
  logic [NUM_DIG-1:0]     digit_blank;

  zbd_code_latch #(.W(NUM_DIG*CW)) u_latch (
    .clk(clk), .rst(rst), .load_n(load_n), .d(digits_in), .q(lat_codes)
  );

  zbd_pwm_gen #(.PWM_W(PWM_W)) u_pwm (
    .clk(clk), .rst(rst), .level(brightness), .cnt(pwm_cnt), .on(pwm_on)
  );

  // Integer chain: head is the most significant digit, tail is the units digit
  for (genvar i = 0; i < NUM_INT; i++) begin : g_int_map
    assign int_codes[i*CW +: CW]    = lat_codes[(NUM_DIG-1-i)*CW +: CW];
    assign digit_blank[NUM_DIG-1-i] = int_blank[i];
  end

  // Fraction chain: head is the least significant digit, moving toward the point
  assign frac_codes = lat_codes[NUM_FRAC*CW-1:0];
  for (genvar j = 0; j < NUM_FRAC; j++) begin : g_frac_map
    assign digit_blank[j] = frac_blank[j];
  end

  zbd_ripple_chain #(.N(NUM_INT), .KEEP_TAIL(1'b1)) u_int_chain (
    .codes(int_codes), .blank(int_blank)
  );

  zbd_ripple_chain #(.N(NUM_FRAC), .KEEP_TAIL(1'b0)) u_frac_chain (
    .codes(frac_codes), .blank(frac_blank)
  );

  for (genvar k = 0; k < NUM_DIG; k++) begin : g_digit
    zbd_digit_driver u_drv (
      .clk     (clk),
      .rst     (rst),
      .code    (lat_codes[k*CW +: CW]),
      .suppress(digit_blank[k]),
      .pwm_on  (pwm_on),
      .seg_n   (seg_n[k*SW +: SW])
    );
  end
endmodule

// File: rtl/zbd_checker.sv
module zbd_checker #(
  parameter int NUM_INT  = 4,
  parameter int NUM_FRAC = 4,
  parameter int PWM_W    = 8,
  localparam int NUM_DIG = NUM_INT + NUM_FRAC,
  localparam int CW      = 4,
  localparam int SW      = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  load_n,
  input logic [PWM_W-1:0]      brightness,
  input logic [NUM_DIG*SW-1:0] seg_n,
  input logic [NUM_DIG*CW-1:0] lat_codes,
  input logic [PWM_W-1:0]      pwm_cnt
);
  localparam int TOP  = NUM_DIG-1;
  localparam int UNIT = NUM_FRAC;

  logic lit_now;
  assign lit_now = (pwm_cnt < brightness);

  p_reset_dark_r9: assert property (@(posedge clk)
    $past(rst) |-> (seg_n == '1));

  p_zero_level_dark_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(brightness) == '0) |-> (seg_n == '1));

  p_units_shown_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lit_now) && $past(lat_codes[UNIT*CW +: CW]) != 4'hF)
      |-> (seg_n[UNIT*SW +: SW] != '1));

  p_top_zero_dark_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lat_codes[TOP*CW +: CW]) == '0)
      |-> (seg_n[TOP*SW +: SW] == '1));

  p_last_frac_zero_dark_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lat_codes[CW-1:0]) == '0) |-> (seg_n[SW-1:0] == '1));

  p_nondec_stops_chain_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lit_now) && $past(lat_codes[TOP*CW +: CW]) >= 4'd10
       && $past(lat_codes[(TOP-1)*CW +: CW]) == '0)
      |-> (seg_n[(TOP-1)*SW +: SW] == 7'h40));

  p_codes_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_n)) |-> $stable(lat_codes));
endmodule

bind zero_blank_display zbd_checker #(
  .NUM_INT(NUM_INT), .NUM_FRAC(NUM_FRAC), .PWM_W(PWM_W)
) u_chk (
  .clk(clk), .rst(rst), .load_n(load_n), .brightness(brightness),
  .seg_n(seg_n), .lat_codes(lat_codes), .pwm_cnt(pwm_cnt)
);

// File: tb/zero_blank_display_bench.sv
module zero_blank_display_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 8;
  localparam logic [55:0] DARK = '1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_n = 1'b1;
  logic [31:0] digits_in = '0;
  logic [7:0]  brightness = 8'd255;
  logic [55:0] seg_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  zero_blank_display u_zero_blank_display (
    .clk(clk), .rst(rst), .load_n(load_n), .digits_in(digits_in),
    .brightness(brightness), .seg_n(seg_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] ref_glyph(logic [3:0] c);
    case (c)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;  10: return 7'h40; 11: return 7'h79;
      12: return 7'h76; 13: return 7'h38; 14: return 7'h73; default: return 7'h00;
    endcase
  endfunction

  // R3, R4, R5, R6: expected segments for a stored value, fully lit
  function automatic logic [55:0] ref_display(logic [31:0] c);
    logic [55:0] r;
    logic run;
    logic [7:0] bl;
    bl = '0;
    run = 1'b1;
    for (int i = 7; i >= 4; i--) begin
      if (i == 4) bl[i] = 1'b0;
      else        bl[i] = run && (c[i*4 +: 4] == 4'd0);
      run = bl[i];
    end
    run = 1'b1;
    for (int j = 0; j <= 3; j++) begin
      bl[j] = run && (c[j*4 +: 4] == 4'd0);
      run = bl[j];
    end
    for (int k = 0; k < ND; k++)
      r[k*7 +: 7] = bl[k] ? 7'h7F : ~ref_glyph(c[k*4 +: 4]);
    return r;
  endfunction

  // Reference pipeline: stored codes, on-time counter, registered output
  logic [31:0] m_lat;
  logic [7:0]  m_cnt;
  logic [55:0] exp_seg;
  always @(posedge clk) begin
    if (rst) begin
      m_lat <= '0; m_cnt <= '0; exp_seg <= DARK;
    end else begin
      if (!load_n) m_lat <= digits_in;
      m_cnt <= m_cnt + 8'd1;
      exp_seg <= (m_cnt < brightness) ? ref_display(m_lat) : DARK;
    end
  end

  task automatic check_now(string tag);
    @(negedge clk);
    n_chk++;
    if (seg_n !== exp_seg) begin
      n_bad++;
      $display("FAIL %s: seg_n=%h expected=%h", tag, seg_n, exp_seg);
    end
  endtask

  task automatic load_and_check(logic [31:0] codes, string tag);
    @(negedge clk);
    digits_in = codes;
    load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    digits_in = $urandom;  // R7: ignored while strobe is high
    check_now(tag);
  endtask

  task automatic duty_check(logic [7:0] lvl, string tag);
    int lit_cnt;
    @(negedge clk);
    brightness = lvl;
    repeat (3) @(negedge clk);
    lit_cnt = 0;
    for (int t = 0; t < 256; t++) begin
      @(negedge clk);
      if (seg_n !== DARK) lit_cnt++;
    end
    n_chk++;
    if (lit_cnt != int'(lvl)) begin
      n_bad++;
      $display("FAIL %s: lit cycles=%0d expected=%0d", tag, lit_cnt, lvl);
    end
  endtask

  function automatic logic [31:0] rand_value();
    logic [31:0] v;
    for (int k = 0; k < ND; k++)
      v[k*4 +: 4] = ($urandom % 2 == 0) ? 4'd0 : 4'($urandom % 16);
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    // R9: reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if (seg_n !== DARK) begin
      n_bad++;
      $display("FAIL R9: seg_n=%h expected=%h", seg_n, DARK);
    end
    rst = 1'b0;
    check_now("R9 after release");
    check_now("R4 zero value units shown");

    // R10 with a hand-built expected value
    load_and_check(32'h0060_0300, "R10 model");
    while (exp_seg === DARK) @(negedge clk);
    n_chk++;
    if (seg_n !== {7'h7F, 7'h7F, ~7'h7D, ~7'h3F, ~7'h3F, ~7'h4F, 7'h7F, 7'h7F}) begin
      n_bad++;
      $display("FAIL R10: seg_n=%h expected=%h", seg_n,
               {7'h7F, 7'h7F, ~7'h7D, ~7'h3F, ~7'h3F, ~7'h4F, 7'h7F, 7'h7F});
    end

    load_and_check(32'h0000_0000, "R4 R5 all zero");
    load_and_check(32'h1000_0001, "R3 R5 inner zeros kept");
    load_and_check(32'h0000_5000, "R5 first fraction only");
    load_and_check(32'h0123_4567, "R1 digits 1-7");
    load_and_check(32'h8900_0089, "R1 digits 8 9");
    load_and_check(32'hABCD_EF00, "R2 glyphs");
    load_and_check(32'hF000_000F, "R6 code 15 stops chains");
    load_and_check(32'h0A00_00B0, "R6 codes stop chains");
    load_and_check(32'h0002_0000, "R3 R4 units only");

    // R7: strobe held high, new codes ignored
    @(negedge clk);
    digits_in = 32'h9999_9999;
    repeat (3) check_now("R7 hold without strobe");

    // Random mix, R1 R3 R5 R6 R7
    for (int n = 0; n < 300; n++) begin
      if (n % 50 == 0) brightness = 8'($urandom);
      load_and_check(rand_value(), "R3 R5 random");
      check_now("R8 random dimmed");
    end

    // R8 duty counts
    load_and_check(32'h8888_8888, "R8 setup");
    duty_check(8'd0,   "R8 level 0");
    duty_check(8'd1,   "R8 level 1");
    duty_check(8'd128, "R8 level 128");
    duty_check(8'd255, "R8 level 255");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule